// File: doc/BRIEF.md
# Byte ALU with Per-Operation Status Flags

This block is the arithmetic and logic unit of a small 8-bit RISC core. An operation is issued together with two byte operands (register or immediate), the current status byte, a 3-bit bit selector and a 6-bit word immediate. The block returns the result byte, the next status byte, a write-back indication and a branch-condition bit. Each operation rewrites only the status flags that belong to it, and every other flag is copied through from the incoming status byte.

Byte operations finish one clock after issue. The register-pair add or subtract of a 6-bit immediate takes two clocks. The block reports `busy` during its second cycle and ignores any issue made while busy. The register file, decode, memory, interrupts and program counter belong to the surrounding core.

Top module: `flag_alu`

## Requirements
- R1: The status byte is laid out with interrupt-enable at bit 7, transfer at bit 6, half-carry at bit 5, sign at bit 4, overflow at bit 3, negative at bit 2, zero at bit 1 and carry at bit 0. `opSel` encodes ADD=0, ADC=1, SUB=2, SBC=3, CMP=4, CMPC=5, NEG=6, AND=7, OR=8, XOR=9, COM=10, INC=11, DEC=12, TST=13, LSL=14, LSR=15, ROL=16, ROR=17, ASR=18, SWAP=19, FSET=20, FCLR=21, TGET=22, TPUT=23, BRSET=24, BRCLR=25, BRGE=26, BRLT=27, WADD=28, WSUB=29. Codes 30 and 31 change nothing and write nothing back.
- R2: ADD, ADC, SUB, SBC, CMP, CMPC and NEG update only the zero, carry, negative, overflow, half-carry and sign flags, with sign equal to negative xor overflow. ADC, SBC and CMPC also consume the incoming carry. CMP and CMPC present the difference with `writeBack` low.
- R3: For SBC and CMPC, the zero flag is set only if the result is zero and the incoming zero flag was already set. A nonzero result clears it.
- R4: AND, OR, XOR, INC, DEC and TST update only zero, negative, overflow and sign. Overflow is cleared for the logic operations. INC sets overflow only on 0x7F to 0x80, and DEC sets it only on 0x80 to 0x7F. TST returns operand A unchanged.
- R5: COM returns 0xFF minus A, sets carry and clears overflow. NEG returns 0x00 minus A, with its flags following subtraction from zero.
- R6: LSL, LSR, ROL, ROR and ASR update zero, carry, negative, overflow and sign, where overflow is negative xor the new carry. LSR fills bit 7 with 0, ASR keeps bit 7, and ROL and ROR rotate through the incoming carry.
- R7: SWAP exchanges the nibbles of A and leaves the status byte unchanged. FSET and FCLR set or clear status bit `bitSel`. TGET copies bit `bitSel` of A into the transfer flag and writes nothing back. TPUT returns A with bit `bitSel` replaced by the transfer flag and changes no flag.
- R8: WADD and WSUB add or subtract the zero-extended `immWord` to or from the pair {opB, opA}, returning the low byte on `result` and the high byte on `resultHi`. They update zero, carry, negative, overflow and sign from the 16-bit result. Results appear two clocks after issue, with `busy` high in between.
- R9: BRSET and BRCLR make `condTrue` equal status bit `bitSel` or its inverse. BRGE is true when negative xor overflow is 0, and BRLT when it is 1. These operations change no flag and write nothing back.
- R10: A byte operation raises `resValid` for exactly one cycle, one clock after issue. An issue made while `busy` is high is ignored.
- R11: While reset is low, every output is driven to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Start an operation this cycle |
| opSel | input | 5 | Operation code |
| opA | input | 8 | Operand A; low byte of the pair for word operations |
| opB | input | 8 | Operand B (register or immediate); high byte of the pair |
| immWord | input | 6 | Unsigned immediate for word add and subtract |
| bitSel | input | 3 | Bit selector for flag, transfer and branch operations |
| statusIn | input | 8 | Current status byte |
| busy | output | 1 | Second cycle of a word operation |
| resValid | output | 1 | Result, status and condition are valid |
| writeBack | output | 1 | Result is to be written to the destination |
| result | output | 8 | Result byte (low byte for word operations) |
| resultHi | output | 8 | High byte of a word result; zero otherwise |
| statusOut | output | 8 | Next status byte |
| condTrue | output | 1 | Branch condition outcome |

## Verification
Every byte operation is due on the first rising edge after issue, so the bench drives on the falling edge and compares `result`, `statusOut`, `condTrue` and `writeBack` on the next falling edge. Word operations are due one edge later. At the intermediate falling edge the bench checks that `busy` is high and `resValid` low. One falling edge after each result, it checks that `resValid` has dropped, which also shows that an issue made while busy produced no extra result. The expected values come from an integer-arithmetic model in the bench that uses signed ranges and nibble sums rather than bit formulas.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int STAT_W = 8;
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int FL_T = 6;

  localparam logic [STAT_W-1:0] MASK_ARITH = 8'b0011_1111;
  localparam logic [STAT_W-1:0] MASK_LOGIC = 8'b0001_1110;
  localparam logic [STAT_W-1:0] MASK_SHIFT = 8'b0001_1111;
  localparam logic [STAT_W-1:0] MASK_WORD  = 8'b0001_1111;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0, OP_ADC = 5'd1, OP_SUB = 5'd2, OP_SBC = 5'd3,
    OP_CMP = 5'd4, OP_CMPC = 5'd5, OP_NEG = 5'd6, OP_AND = 5'd7,
    OP_OR = 5'd8, OP_XOR = 5'd9, OP_COM = 5'd10, OP_INC = 5'd11,
    OP_DEC = 5'd12, OP_TST = 5'd13, OP_LSL = 5'd14, OP_LSR = 5'd15,
    OP_ROL = 5'd16, OP_ROR = 5'd17, OP_ASR = 5'd18, OP_SWAP = 5'd19,
    OP_FSET = 5'd20, OP_FCLR = 5'd21, OP_TGET = 5'd22, OP_TPUT = 5'd23,
    OP_BRSET = 5'd24, OP_BRCLR = 5'd25, OP_BRGE = 5'd26, OP_BRLT = 5'd27,
    OP_WADD = 5'd28, OP_WSUB = 5'd29, OP_RSV0 = 5'd30, OP_RSV1 = 5'd31
  } op_e;

  typedef struct packed {
    logic [STAT_W-1:0] flagMask;
    logic              writeBack;
    logic              zChain;
    logic              byteFire;
    logic              loadWord;
    logic              finishWord;
  } strobe_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       issue,
  input  op_e        opCode,
  input  logic [2:0] flagSel,
  output strobe_t    stb,
  output logic       busy
);
  logic wordPhase;
  logic isWord;
  logic accept;

  assign isWord = (opCode == OP_WADD) || (opCode == OP_WSUB);
  assign accept = issue && !wordPhase;
  assign busy   = wordPhase;

  always_ff @(posedge clk) begin
    if (!rstN)                 wordPhase <= 1'b0;
    else if (wordPhase)        wordPhase <= 1'b0;
    else if (accept && isWord) wordPhase <= 1'b1;
  end

  always_comb begin
    stb = '0;
    if (wordPhase) begin
      stb.finishWord = 1'b1;
      stb.flagMask   = MASK_WORD;
      stb.writeBack  = 1'b1;
    end else begin
      stb.byteFire = accept && !isWord;
      stb.loadWord = accept && isWord;
      unique case (opCode)
        OP_ADD, OP_ADC, OP_SUB, OP_NEG: begin
          stb.flagMask = MASK_ARITH; stb.writeBack = 1'b1;
        end
        OP_SBC: begin
          stb.flagMask = MASK_ARITH; stb.writeBack = 1'b1; stb.zChain = 1'b1;
        end
        OP_CMP:  stb.flagMask = MASK_ARITH;
        OP_CMPC: begin
          stb.flagMask = MASK_ARITH; stb.zChain = 1'b1;
        end
        OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_TST: begin
          stb.flagMask = MASK_LOGIC; stb.writeBack = 1'b1;
        end
        OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
          stb.flagMask = MASK_SHIFT; stb.writeBack = 1'b1;
        end
        OP_SWAP, OP_TPUT: stb.writeBack = 1'b1;
        OP_FSET, OP_FCLR: stb.flagMask = STAT_W'(1) << flagSel;
        OP_TGET: stb.flagMask = STAT_W'(1) << FL_T;
        default: stb.flagMask = '0;
      endcase
    end
  end
endmodule

// File: rtl/alu_dp.sv
module alu_dp
  import alu_pkg::*;
#(
  parameter int W     = 8,
  parameter int IMM_W = 6,
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  op_e               opCode,
  input  logic [W-1:0]      opA,
  input  logic [W-1:0]      opB,
  input  logic [IMM_W-1:0]  immWord,
  input  logic [SEL_W-1:0]  bitSel,
  input  logic [STAT_W-1:0] statusIn,
  input  strobe_t           stb,
  output logic              resValid,
  output logic              writeBack,
  output logic [W-1:0]      result,
  output logic [W-1:0]      resultHi,
  output logic [STAT_W-1:0] statusOut,
  output logic              condTrue
);
  localparam int HALF = W / 2;
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic              cOld, subOp, cin, shiftOp;
  logic [W-1:0]      xIn, yIn, res;
  logic [W:0]        full;
  logic [HALF:0]     nib;
  logic              arithV, cNew, hNew, vNew, zNew, nNew, cond;
  logic [STAT_W-1:0] cand;

  assign cOld = statusIn[FL_C];

  always_comb begin
    subOp = opCode inside {OP_SUB, OP_SBC, OP_CMP, OP_CMPC, OP_NEG};
    cin   = (opCode inside {OP_ADC, OP_SBC, OP_CMPC}) && cOld;
    xIn   = (opCode == OP_NEG) ? '0 : opA;
    yIn   = (opCode == OP_NEG) ? opA : opB;
    if (subOp) begin
      full = {1'b0, xIn} - {1'b0, yIn} - {{W{1'b0}}, cin};
      nib  = {1'b0, xIn[HALF-1:0]} - {1'b0, yIn[HALF-1:0]} - {{HALF{1'b0}}, cin};
      arithV = (xIn[W-1] != yIn[W-1]) && (full[W-1] != xIn[W-1]);
    end else begin
      full = {1'b0, xIn} + {1'b0, yIn} + {{W{1'b0}}, cin};
      nib  = {1'b0, xIn[HALF-1:0]} + {1'b0, yIn[HALF-1:0]} + {{HALF{1'b0}}, cin};
      arithV = (xIn[W-1] == yIn[W-1]) && (full[W-1] != xIn[W-1]);
    end
  end

  always_comb begin
    res     = '0;
    cNew    = cOld;
    hNew    = statusIn[FL_H];
    vNew    = 1'b0;
    shiftOp = 1'b0;
    cond    = 1'b0;
    unique case (opCode)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CMPC, OP_NEG: begin
        res = full[W-1:0]; cNew = full[W]; hNew = nib[HALF]; vNew = arithV;
      end
      OP_AND: res = opA & opB;
      OP_OR:  res = opA | opB;
      OP_XOR: res = opA ^ opB;
      OP_TST: res = opA;
      OP_INC: begin res = opA + 1'b1; vNew = (opA == MAX_POS); end
      OP_DEC: begin res = opA - 1'b1; vNew = (opA == MIN_NEG); end
      OP_COM: begin res = ~opA; cNew = 1'b1; end
      OP_LSL: begin res = {opA[W-2:0], 1'b0};    cNew = opA[W-1]; shiftOp = 1'b1; end
      OP_ROL: begin res = {opA[W-2:0], cOld};    cNew = opA[W-1]; shiftOp = 1'b1; end
      OP_LSR: begin res = {1'b0, opA[W-1:1]};    cNew = opA[0];   shiftOp = 1'b1; end
      OP_ROR: begin res = {cOld, opA[W-1:1]};    cNew = opA[0];   shiftOp = 1'b1; end
      OP_ASR: begin res = {opA[W-1], opA[W-1:1]}; cNew = opA[0];  shiftOp = 1'b1; end
      OP_SWAP: res = {opA[HALF-1:0], opA[W-1:HALF]};
      OP_TPUT: begin res = opA; res[bitSel] = statusIn[FL_T]; end
      OP_BRSET: cond = statusIn[bitSel[2:0]];
      OP_BRCLR: cond = !statusIn[bitSel[2:0]];
      OP_BRGE:  cond = !(statusIn[FL_N] ^ statusIn[FL_V]);
      OP_BRLT:  cond = statusIn[FL_N] ^ statusIn[FL_V];
      default: res = '0;
    endcase
    nNew = res[W-1];
    if (shiftOp) vNew = nNew ^ cNew;
    zNew = (res == '0) && (!stb.zChain || statusIn[FL_Z]);
    if (opCode == OP_FSET)      cand = '1;
    else if (opCode == OP_FCLR) cand = '0;
    else begin
      cand       = statusIn;
      cand[FL_C] = cNew;
      cand[FL_Z] = zNew;
      cand[FL_N] = nNew;
      cand[FL_V] = vNew;
      cand[FL_S] = nNew ^ vNew;
      cand[FL_H] = hNew;
      cand[FL_T] = opA[bitSel];
    end
  end

  // word path: low half at issue, high half (incrementer only) one cycle later
  logic [W:0]        lowSum;
  logic [W-1:0]      hiSave;
  logic              subSave;
  logic [STAT_W-1:0] statSave;
  logic [W:0]        hiSum;
  logic              wN, wC, wV, wZ;
  logic [STAT_W-1:0] wCand;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowSum <= '0; hiSave <= '0; subSave <= 1'b0; statSave <= '0;
    end else if (stb.loadWord) begin
      subSave  <= (opCode == OP_WSUB);
      hiSave   <= opB;
      statSave <= statusIn;
      lowSum   <= (opCode == OP_WSUB) ? {1'b0, opA} - {{(W+1-IMM_W){1'b0}}, immWord}
                                      : {1'b0, opA} + {{(W+1-IMM_W){1'b0}}, immWord};
    end
  end

  always_comb begin
    hiSum = subSave ? {1'b0, hiSave} - {{W{1'b0}}, lowSum[W]}
                    : {1'b0, hiSave} + {{W{1'b0}}, lowSum[W]};
    wN = hiSum[W-1];
    wC = subSave ? (wN && !hiSave[W-1]) : (!wN && hiSave[W-1]);
    wV = subSave ? (hiSave[W-1] && !wN) : (!hiSave[W-1] && wN);
    wZ = ({hiSum[W-1:0], lowSum[W-1:0]} == '0);
    wCand       = statSave;
    wCand[FL_C] = wC;
    wCand[FL_Z] = wZ;
    wCand[FL_N] = wN;
    wCand[FL_V] = wV;
    wCand[FL_S] = wN ^ wV;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0; writeBack <= 1'b0; result <= '0;
      resultHi <= '0; statusOut <= '0; condTrue <= 1'b0;
    end else if (stb.finishWord) begin
      resValid  <= 1'b1;
      writeBack <= 1'b1;
      result    <= lowSum[W-1:0];
      resultHi  <= hiSum[W-1:0];
      statusOut <= (statSave & ~stb.flagMask) | (wCand & stb.flagMask);
      condTrue  <= 1'b0;
    end else if (stb.byteFire) begin
      resValid  <= 1'b1;
      writeBack <= stb.writeBack;
      result    <= res;
      resultHi  <= '0;
      statusOut <= (statusIn & ~stb.flagMask) | (cand & stb.flagMask);
      condTrue  <= cond;
    end else begin
      resValid  <= 1'b0;
      writeBack <= 1'b0;
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
#(
  parameter int W     = 8,
  parameter int IMM_W = 6,
  localparam int SEL_W = $clog2(W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issue,
  input  logic [4:0]        opSel,
  input  logic [W-1:0]      opA,
  input  logic [W-1:0]      opB,
  input  logic [IMM_W-1:0]  immWord,
  input  logic [SEL_W-1:0]  bitSel,
  input  logic [STAT_W-1:0] statusIn,
  output logic              busy,
  output logic              resValid,
  output logic              writeBack,
  output logic [W-1:0]      result,
  output logic [W-1:0]      resultHi,
  output logic [STAT_W-1:0] statusOut,
  output logic              condTrue
);
  strobe_t stb;
  op_e     opCode;

  assign opCode = op_e'(opSel);

  alu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .issue(issue), .opCode(opCode),
    .flagSel(bitSel[2:0]), .stb(stb), .busy(busy)
  );

  alu_dp #(.W(W), .IMM_W(IMM_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .opCode(opCode), .opA(opA), .opB(opB),
    .immWord(immWord), .bitSel(bitSel), .statusIn(statusIn), .stb(stb),
    .resValid(resValid), .writeBack(writeBack), .result(result),
    .resultHi(resultHi), .statusOut(statusOut), .condTrue(condTrue)
  );
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W     = 8,
  parameter int IMM_W = 6,
  localparam int SEL_W = $clog2(W)
) (
  input logic              clk,
  input logic              rstN,
  input logic              issue,
  input logic [4:0]        opSel,
  input logic [W-1:0]      opA,
  input logic [W-1:0]      opB,
  input logic [IMM_W-1:0]  immWord,
  input logic [SEL_W-1:0]  bitSel,
  input logic [7:0]        statusIn,
  input logic              busy,
  input logic              resValid,
  input logic              writeBack,
  input logic [W-1:0]      result,
  input logic [W-1:0]      resultHi,
  input logic [7:0]        statusOut,
  input logic              condTrue
);
  logic wordSel;
  assign wordSel = (opSel == 5'd28) || (opSel == 5'd29);

  assert_byte_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    (issue && !busy && !wordSel) |=> (resValid && !busy));

  assert_word_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    (issue && !busy && wordSel) |=> (busy && !resValid));

  assert_word_second_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (resValid && !busy));

  assert_swap_flags_R7: assert property (@(posedge clk) disable iff (!rstN)
    (issue && !busy && opSel == 5'd19) |=> (statusOut == $past(statusIn)));

  assert_logic_sign_R4: assert property (@(posedge clk) disable iff (!rstN)
    (issue && !busy && opSel inside {5'd7, 5'd8, 5'd9}) |=>
      (!statusOut[3] && (statusOut[4] == statusOut[2]) &&
       statusOut[7:5] == $past(statusIn[7:5]) && statusOut[0] == $past(statusIn[0])));

  assert_cmp_nowrite_R2: assert property (@(posedge clk) disable iff (!rstN)
    (issue && !busy && opSel inside {5'd4, 5'd5}) |=>
      (!writeBack && statusOut[7:6] == $past(statusIn[7:6])));

  assert_hi_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (issue && !busy && !wordSel) |=> (resultHi == '0));
endmodule

bind flag_alu flag_alu_chk #(.W(W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/test_flag_alu.sv
module test_flag_alu;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       issue = 1'b0;
  logic [4:0] opSel = '0;
  logic [7:0] opA = '0, opB = '0, statusIn = '0;
  logic [5:0] immWord = '0;
  logic [2:0] bitSel = '0;
  logic       busy, resValid, writeBack, condTrue;
  logic [7:0] result, resultHi, statusOut;

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flag_alu i_flag_alu (
    .clk(clk), .rstN(rstN), .issue(issue), .opSel(opSel), .opA(opA), .opB(opB),
    .immWord(immWord), .bitSel(bitSel), .statusIn(statusIn), .busy(busy),
    .resValid(resValid), .writeBack(writeBack), .result(result),
    .resultHi(resultHi), .statusOut(statusOut), .condTrue(condTrue)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int sgn8(input int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // behavioural reference built on integer arithmetic
  function automatic void refModel(input int op, a, b, st, bs, imm,
                                   output int eRes, eHi, eSt, eCond, eWb);
    int c, z, n, v, h, r, sv, cin, pair, sp, sr;
    bit upd, updH, chain, wordOp;
    c = st & 1; z = (st >> 1) & 1; h = (st >> 5) & 1; v = 0;
    eRes = 0; eHi = 0; eSt = st; eCond = 0; eWb = 1; r = 0;
    upd = 1; updH = 0; chain = 0; wordOp = 0;
    cin = (op == 1 || op == 3 || op == 5) ? c : 0;
    case (op)
      0, 1: begin
        r = a + b + cin; c = (r > 255); h = ((a & 15) + (b & 15) + cin > 15);
        sv = sgn8(a) + sgn8(b) + cin; v = (sv > 127 || sv < -128); updH = 1;
      end
      2, 3, 4, 5, 6: begin
        int x, y;
        x = (op == 6) ? 0 : a; y = (op == 6) ? a : b;
        r = x - y - cin; c = (r < 0); h = ((x & 15) < (y & 15) + cin);
        sv = sgn8(x) - sgn8(y) - cin; v = (sv > 127 || sv < -128); updH = 1;
        chain = (op == 3 || op == 5); if (op == 4 || op == 5) eWb = 0;
      end
      7: r = a & b;
      8: r = a | b;
      9: r = a ^ b;
      10: begin r = 255 - a; c = 1; end
      11: begin r = a + 1; v = (a == 127); end
      12: begin r = a - 1; v = (a == 128); end
      13: r = a;
      14: begin r = a * 2; c = a >> 7; end
      15: begin r = a / 2; c = a & 1; end
      16: begin r = a * 2 + (st & 1); c = a >> 7; end
      17: begin r = a / 2 + 128 * (st & 1); c = a & 1; end
      18: begin r = a / 2 + (a & 128); c = a & 1; end
      19: begin r = (a % 16) * 16 + a / 16; upd = 0; end
      20: begin eSt = st | (1 << bs); upd = 0; eWb = 0; end
      21: begin eSt = st & ~(1 << bs); upd = 0; eWb = 0; end
      22: begin eSt = (st & 8'hBF) | (((a >> bs) & 1) << 6); upd = 0; eWb = 0; end
      23: begin r = (a & ~(1 << bs)) | (((st >> 6) & 1) << bs); upd = 0; end
      24: begin eCond = (st >> bs) & 1; upd = 0; eWb = 0; end
      25: begin eCond = 1 - ((st >> bs) & 1); upd = 0; eWb = 0; end
      26: begin eCond = (((st >> 2) ^ (st >> 3)) & 1) == 0; upd = 0; eWb = 0; end
      27: begin eCond = ((st >> 2) ^ (st >> 3)) & 1; upd = 0; eWb = 0; end
      28, 29: begin
        wordOp = 1; pair = b * 256 + a;
        sp = (pair > 32767) ? pair - 65536 : pair;
        if (op == 28) begin r = pair + imm; c = (r > 65535); sr = sp + imm; end
        else begin r = pair - imm; c = (r < 0); sr = sp - imm; end
        v = (sr > 32767 || sr < -32768);
        r = r & 16'hFFFF;
        eRes = r & 255; eHi = r >> 8;
        z = (r == 0); n = r >> 15;
        eSt = (st & 8'hE0) | (((n ^ v) & 1) << 4) | (v << 3) | (n << 2) | (z << 1) | c;
        upd = 0;
      end
      default: begin upd = 0; eWb = 0; end
    endcase
    if (!wordOp) begin
      r = r & 255;
      if (op != 20 && op != 21 && op != 22 && op < 24) eRes = r;
    end
    if (upd) begin
      n = r >> 7;
      if (op >= 14 && op <= 18) v = n ^ c;
      z = (r == 0) && (!chain || ((st >> 1) & 1));
      eSt = st & 8'hE0;
      if (op >= 7 && op <= 13 && op != 10) eSt = eSt | (st & 1);
      else eSt = eSt | c;
      if (updH) eSt = (eSt & 8'hDF) | (h << 5);
      eSt = eSt | (((n ^ v) & 1) << 4) | (v << 3) | (n << 2) | (z << 1);
    end
  endfunction

  task automatic runOp(input int op, a, b, st, bs, imm, input string tag);
    int eRes, eHi, eSt, eCond, eWb, act, exp;
    refModel(op, a, b, st, bs, imm, eRes, eHi, eSt, eCond, eWb);
    @(negedge clk);
    issue = 1'b1; opSel = op[4:0]; opA = a[7:0]; opB = b[7:0];
    statusIn = st[7:0]; bitSel = bs[2:0]; immWord = imm[5:0];
    @(negedge clk);
    issue = 1'b0;
    if (op == 28 || op == 29) begin
      check(busy && !resValid, {tag, " busy phase"}, {busy, resValid}, 2);
      @(negedge clk);
    end
    act = {resValid, writeBack, condTrue, resultHi, result, statusOut};
    exp = {1'b1, eWb[0], eCond[0], eHi[7:0], eRes[7:0], eSt[7:0]};
    check(act == exp, tag, act, exp);
    @(negedge clk);
    check(!resValid, {tag, " R10 pulse"}, resValid, 0);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      nErrors++; nChecks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, resValid, writeBack, condTrue, result, resultHi, statusOut} == '0,
          "R11 reset", {result, statusOut}, 0);
    rstN = 1'b1;
    // R1/R2 arithmetic
    runOp(0, 8'h7F, 8'h01, 8'hC0, 0, 0, "R1 R2 add overflow");
    runOp(0, 8'hFF, 8'h01, 8'h00, 0, 0, "R2 add carry zero");
    runOp(1, 8'h0E, 8'h01, 8'h01, 0, 0, "R2 adc carry-in");
    runOp(2, 8'h00, 8'h01, 8'h40, 0, 0, "R2 sub borrow");
    runOp(2, 8'h80, 8'h01, 8'h00, 0, 0, "R2 sub overflow");
    runOp(4, 8'h10, 8'h20, 8'h80, 0, 0, "R2 cmp no write");
    // R3 zero chaining
    runOp(3, 8'h05, 8'h05, 8'h00, 0, 0, "R3 sbc zero held low");
    runOp(3, 8'h05, 8'h05, 8'h02, 0, 0, "R3 sbc zero kept");
    runOp(5, 8'h06, 8'h05, 8'h03, 0, 0, "R3 cmpc zero with carry");
    runOp(5, 8'h07, 8'h05, 8'h02, 0, 0, "R3 cmpc nonzero clears");
    // R5
    runOp(6, 8'h80, 0, 8'h00, 0, 0, "R5 neg 0x80");
    runOp(6, 8'h00, 0, 8'h3F, 0, 0, "R5 neg zero");
    runOp(10, 8'h55, 0, 8'h00, 0, 0, "R5 com");
    // R4
    runOp(7, 8'hF0, 8'h8F, 8'h29, 0, 0, "R4 and");
    runOp(8, 8'h00, 8'h00, 8'h08, 0, 0, "R4 or zero");
    runOp(9, 8'hAA, 8'h55, 8'h21, 0, 0, "R4 xor");
    runOp(11, 8'h7F, 0, 8'h21, 0, 0, "R4 inc overflow");
    runOp(12, 8'h80, 0, 8'h00, 0, 0, "R4 dec overflow");
    runOp(12, 8'h01, 0, 8'h08, 0, 0, "R4 dec to zero");
    runOp(13, 8'h00, 0, 8'h01, 0, 0, "R4 tst");
    // R6
    runOp(14, 8'h81, 0, 8'h00, 0, 0, "R6 lsl");
    runOp(15, 8'h01, 0, 8'h00, 0, 0, "R6 lsr");
    runOp(16, 8'h40, 0, 8'h01, 0, 0, "R6 rol");
    runOp(17, 8'h02, 0, 8'h01, 0, 0, "R6 ror");
    runOp(18, 8'h81, 0, 8'h00, 0, 0, "R6 asr");
    // R7
    runOp(19, 8'h3C, 0, 8'hA5, 0, 0, "R7 swap");
    runOp(20, 0, 0, 8'h00, 7, 0, "R7 fset");
    runOp(21, 0, 0, 8'hFF, 0, 0, "R7 fclr");
    runOp(22, 8'h20, 0, 8'h00, 5, 0, "R7 tget");
    runOp(23, 8'h00, 0, 8'h40, 3, 0, "R7 tput");
    // R9
    runOp(24, 0, 0, 8'h04, 2, 0, "R9 brset");
    runOp(25, 0, 0, 8'h04, 2, 0, "R9 brclr");
    runOp(26, 0, 0, 8'h0C, 0, 0, "R9 brge");
    runOp(27, 0, 0, 8'h04, 0, 0, "R9 brlt");
    // R8
    runOp(28, 8'hFF, 8'h00, 8'hE0, 0, 1, "R8 wadd byte carry");
    runOp(28, 8'hFF, 8'h7F, 8'h00, 0, 1, "R8 wadd overflow");
    runOp(28, 8'hC1, 8'hFF, 8'h00, 0, 63, "R8 wadd wrap zero");
    runOp(29, 8'h00, 8'h00, 8'h00, 0, 1, "R8 wsub borrow");
    runOp(29, 8'h00, 8'h80, 8'h00, 0, 1, "R8 wsub overflow");
    // R10: an issue during busy is dropped
    @(negedge clk);
    issue = 1'b1; opSel = 5'd28; opA = 8'h10; opB = 8'h00; immWord = 6'd2; statusIn = 8'h00;
    @(negedge clk);
    opSel = 5'd0; opA = 8'h01; opB = 8'h01;
    @(negedge clk);
    issue = 1'b0;
    check(resValid && result == 8'h12 && resultHi == 8'h00, "R10 word under busy issue",
          result, 8'h12);
    @(negedge clk);
    check(!resValid, "R10 busy issue ignored", resValid, 0);
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule